// File: doc/BRIEF.md
# Command-Indexed Bank Switch with Fetch-Tracked Mirroring

This block is the bank-switching logic of a game cartridge. The CPU programs it in two steps. A write to the command address picks one of eight bank registers, and a later write to the data address loads that register. Six character registers each hold a bank number and one nametable-select bit. Two program registers hold banks for the first two 8 KB CPU windows. The upper two windows are tied to the last two banks.

The single-screen nametable is not set by a register of its own. The block watches the PPU address bus and latches which 1 KB pattern slot was fetched most recently. The select bit that belongs to that slot drives the nametable A10 line. All bank outputs are combinational from the current address and the stored registers.

Top module: `cmd_bank_mapper`

## Requirements
- R1: A CPU write whose address, masked with 0xF001, equals 0x8000 stores the command. Only its low three bits count. A command write changes none of the outputs.
- R2: A CPU write whose address, masked with 0xF001, equals 0x8001 loads the register selected by the stored command. Command 6 loads the bank for CPU 0x8000–0x9FFF and command 7 loads the bank for 0xA000–0xBFFF, with all 8 data bits. The command stays in place, so later data writes go to the same register.
- R3: Commands 0 to 5 load character registers 0 to 5. Data bits 4:0 become the bank number, bit 5 becomes the register's nametable select, and bits 7:6 are dropped.
- R4: For PPU 0x0000–0x07FF the character bank output is {reg0[4:1], ppuA10}. For 0x0800–0x0FFF it is {reg1[4:1], ppuA10}. The four 1 KB slots at 0x1000, 0x1400, 0x1800 and 0x1C00 output registers 2, 3, 4 and 5 unchanged.
- R5: The select bit of register 0 applies to slots 0 and 1, and that of register 1 applies to slots 2 and 3. Registers 2 to 5 each set the select of one slot, slots 4 to 7.
- R6: The program bank output is 0xFE for CPU 0xC000–0xDFFF and 0xFF for 0xE000–0xFFFF, whatever has been written.
- R7: A PPU access strobe with address bit 13 clear latches address bits 12:10 as the current slot. From the next cycle, ntA10 equals that slot's select bit. Accesses with bit 13 set leave the latch unchanged.
- R8: After reset the command, all bank registers, all selects and the slot latch are 0. The 0x8000 window and all character banks therefore read 0, and ntA10 is 0.
- R9: CPU writes to any other address have no effect on any register.
- R10: A data write that changes the select bit of the currently latched slot shows on ntA10 in the cycle after the write, with no new PPU fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWrEn | input | 1 | CPU write strobe, one cycle per write |
| cpuAddr | input | 16 | CPU address |
| cpuData | input | 8 | CPU write data |
| ppuEn | input | 1 | PPU access strobe |
| ppuAddrHi | input | 4 | PPU address bits 13:10 |
| prgBank | output | 8 | 8 KB program bank for the window addressed by cpuAddr |
| chrBank | output | 5 | 1 KB character bank for the slot addressed by ppuAddrHi |
| ntA10 | output | 1 | Nametable A10 for single-screen mirroring |

## Verification
The hardest case to reach is a change on ntA10 that depends on two separate histories. The slot latch is set only by PPU fetches, and the select bits are set only by CPU data writes. One mistake would be a select from the wrong owner register, for example register 1 failing to cover slot 3. Another would be a latch that also follows nametable-range fetches. Either error stays hidden unless the selects across slots first differ.

The stimulus therefore first loads all six character registers with mixed select bits. It then walks PPU fetches across slots whose selects alternate, with a fetch above 0x2000 placed between them. Last, it rewrites the select of the slot that is currently latched, which checks that the update is applied live.

// File: rtl/cmd_bank_mapper_pkg.sv
package cmd_bank_mapper_pkg;
  localparam int NUM_CHR   = 6;
  localparam int NUM_PRG   = 2;
  localparam int NUM_SLOTS = 8;
  localparam int DATA_W    = 8;

  typedef struct packed {
    logic [NUM_CHR-1:0] chrLoad;
    logic [NUM_PRG-1:0] prgLoad;
    logic [DATA_W-1:0]  value;
  } bank_strobe_t;
endpackage

// File: rtl/mapper_ctrl.sv
module mapper_ctrl
  import cmd_bank_mapper_pkg::*;
#(
  parameter logic [15:0] DEC_MASK = 16'hF001,
  parameter logic [15:0] CMD_ADDR = 16'h8000,
  parameter logic [15:0] DAT_ADDR = 16'h8001
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuWrEn,
  input  logic [15:0]       cpuAddr,
  input  logic [DATA_W-1:0] cpuData,
  output bank_strobe_t      strobe
);
  localparam int CMD_W = $clog2(NUM_CHR + NUM_PRG);

  logic             cmdHit;
  logic             dataHit;
  logic [CMD_W-1:0] cmdQ;

  assign cmdHit  = cpuWrEn && ((cpuAddr & DEC_MASK) == CMD_ADDR);
  assign dataHit = cpuWrEn && ((cpuAddr & DEC_MASK) == DAT_ADDR);

  always_ff @(posedge clk) begin
    if (!rstN)       cmdQ <= '0;
    else if (cmdHit) cmdQ <= cpuData[CMD_W-1:0];
  end

  always_comb begin
    strobe       = '0;
    strobe.value = cpuData;
    for (int i = 0; i < NUM_CHR; i++)
      strobe.chrLoad[i] = dataHit && (cmdQ == CMD_W'(i));
    for (int j = 0; j < NUM_PRG; j++)
      strobe.prgLoad[j] = dataHit && (cmdQ == CMD_W'(NUM_CHR + j));
  end
endmodule

// File: rtl/mapper_datapath.sv
module mapper_datapath
  import cmd_bank_mapper_pkg::*;
#(
  parameter int PRG_W = 8,
  parameter int CHR_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  bank_strobe_t     strobe,
  input  logic [1:0]       prgWin,
  input  logic             ppuEn,
  input  logic [3:0]       ppuAddrHi,
  output logic [PRG_W-1:0] prgBank,
  output logic [CHR_W-1:0] chrBank,
  output logic             ntA10
);
  localparam int SEL_BIT = CHR_W;
  localparam logic [PRG_W-1:0] PRG_LAST   = '1;
  localparam logic [PRG_W-1:0] PRG_SECOND = PRG_LAST - 1'b1;

  logic [CHR_W-1:0]     chrReg  [NUM_CHR];
  logic [PRG_W-1:0]     prgReg  [NUM_PRG];
  logic [NUM_SLOTS-1:0] slotSel;
  logic [2:0]           slotQ;

  for (genvar i = 0; i < NUM_CHR; i++) begin : g_chr
    always_ff @(posedge clk) begin
      if (!rstN)                  chrReg[i] <= '0;
      else if (strobe.chrLoad[i]) chrReg[i] <= strobe.value[CHR_W-1:0];
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    localparam int OWNER = (s < 4) ? (s / 2) : (s - 2);
    always_ff @(posedge clk) begin
      if (!rstN)                      slotSel[s] <= 1'b0;
      else if (strobe.chrLoad[OWNER]) slotSel[s] <= strobe.value[SEL_BIT];
    end
  end

  for (genvar j = 0; j < NUM_PRG; j++) begin : g_prg
    always_ff @(posedge clk) begin
      if (!rstN)                  prgReg[j] <= '0;
      else if (strobe.prgLoad[j]) prgReg[j] <= strobe.value[PRG_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                      slotQ <= '0;
    else if (ppuEn && !ppuAddrHi[3]) slotQ <= ppuAddrHi[2:0];
  end

  assign ntA10 = slotSel[slotQ];

  always_comb begin
    case (prgWin)
      2'd0:    prgBank = prgReg[0];
      2'd1:    prgBank = prgReg[1];
      2'd2:    prgBank = PRG_SECOND;
      default: prgBank = PRG_LAST;
    endcase
  end

  logic [CHR_W-1:0] wideVal;
  logic [CHR_W-1:0] fineVal;

  assign wideVal = chrReg[{2'b00, ppuAddrHi[1]}];
  assign fineVal = chrReg[3'd2 + {1'b0, ppuAddrHi[1:0]}];
  assign chrBank = ppuAddrHi[2] ? fineVal : {wideVal[CHR_W-1:1], ppuAddrHi[0]};
endmodule

// File: rtl/cmd_bank_mapper.sv
module cmd_bank_mapper
  import cmd_bank_mapper_pkg::*;
#(
  parameter int PRG_W = 8,
  parameter int CHR_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuWrEn,
  input  logic [15:0]      cpuAddr,
  input  logic [7:0]       cpuData,
  input  logic             ppuEn,
  input  logic [3:0]       ppuAddrHi,
  output logic [PRG_W-1:0] prgBank,
  output logic [CHR_W-1:0] chrBank,
  output logic             ntA10
);
  bank_strobe_t strobe;

  mapper_ctrl i_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cpuWrEn (cpuWrEn),
    .cpuAddr (cpuAddr),
    .cpuData (cpuData),
    .strobe  (strobe)
  );

  mapper_datapath #(.PRG_W(PRG_W), .CHR_W(CHR_W)) i_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .prgWin    (cpuAddr[14:13]),
    .ppuEn     (ppuEn),
    .ppuAddrHi (ppuAddrHi),
    .prgBank   (prgBank),
    .chrBank   (chrBank),
    .ntA10     (ntA10)
  );
endmodule

// File: rtl/cmd_bank_mapper_sva.sv
module cmd_bank_mapper_sva #(
  parameter int PRG_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             cpuWrEn,
  input logic [15:0]      cpuAddr,
  input logic             ppuEn,
  input logic [3:0]       ppuAddrHi,
  input logic [PRG_W-1:0] prgBank,
  input logic             ntA10
);
  logic patFetch;
  logic decHit;
  assign patFetch = ppuEn && (ppuAddrHi < 4'd8);
  assign decHit   = cpuWrEn && ((cpuAddr & 16'hF000) == 16'h8000);

  // R6: upper windows are fixed
  p_fixed_c000_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr >= 16'hC000 && cpuAddr < 16'hE000) |-> prgBank == {{(PRG_W-1){1'b1}}, 1'b0});
  p_fixed_e000_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr >= 16'hE000) |-> prgBank == {PRG_W{1'b1}});

  // R1: a command write leaves the nametable line alone
  p_cmd_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (decHit && !cpuAddr[0] && !patFetch) |=> $stable(ntA10));

  // R7: nametable-range accesses and idle cycles keep the latch
  p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!cpuWrEn && !patFetch) |=> $stable(ntA10));

  // R9: writes outside the decoded range do nothing
  p_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cpuWrEn && !decHit && !patFetch) |=> $stable(ntA10));
endmodule

bind cmd_bank_mapper cmd_bank_mapper_sva #(.PRG_W(PRG_W)) i_sva (
  .clk       (clk),
  .rstN      (rstN),
  .cpuWrEn   (cpuWrEn),
  .cpuAddr   (cpuAddr),
  .ppuEn     (ppuEn),
  .ppuAddrHi (ppuAddrHi),
  .prgBank   (prgBank),
  .ntA10     (ntA10)
);

// File: tb/test_cmd_bank_mapper.sv
`timescale 1ns/1ps
module test_cmd_bank_mapper;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuWrEn = 1'b0;
  logic [15:0] cpuAddr = '0;
  logic [7:0] cpuData = '0;
  logic       ppuEn = 1'b0;
  logic [3:0] ppuAddrHi = '0;
  logic [7:0] prgBank;
  logic [4:0] chrBank;
  logic       ntA10;

  int testsRun = 0;
  int testsFailed = 0;

  always #2 clk = ~clk;

  cmd_bank_mapper i_cmd_bank_mapper (.*);

  typedef struct packed {
    logic [2:0]  cmd;
    logic [7:0]  data;
    logic        isPpu;
    logic [15:0] addr;
    logic [7:0]  exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{3'd6, 8'h15, 1'b0, 16'h8123, 8'h15},  // R2 window 0x8000
    '{3'd7, 8'hA7, 1'b0, 16'hA000, 8'hA7},  // R2 window 0xA000
    '{3'd0, 8'h0B, 1'b1, 16'h0000, 8'h0A},  // R4 2 KB low half
    '{3'd0, 8'h0B, 1'b1, 16'h0400, 8'h0B},  // R4 2 KB high half
    '{3'd1, 8'h3E, 1'b1, 16'h0C00, 8'h1F},  // R3/R4 reg1 with select
    '{3'd2, 8'hC7, 1'b1, 16'h1000, 8'h07},  // R3 bits 7:6 dropped
    '{3'd3, 8'h13, 1'b1, 16'h1400, 8'h13},  // R4 slot 5
    '{3'd4, 8'h09, 1'b1, 16'h1800, 8'h09},  // R4 slot 6
    '{3'd5, 8'h3A, 1'b1, 16'h1FFF, 8'h1A},  // R3/R4 slot 7 with select
    '{3'd6, 8'hFF, 1'b0, 16'h9FFF, 8'hFF}   // R2 reload window 0x8000
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cpuWrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpuWrEn = 1'b1; cpuAddr = a; cpuData = d;
    @(negedge clk);
    cpuWrEn = 1'b0;
  endtask

  task automatic ppuFetch(input logic [13:0] a);
    @(negedge clk);
    ppuEn = 1'b1; ppuAddrHi = a[13:10];
    @(negedge clk);
    ppuEn = 1'b0;
  endtask

  task automatic prgAt(input logic [15:0] a, output logic [7:0] v);
    cpuAddr = a; #0.5; v = prgBank;
  endtask

  task automatic chrAt(input logic [13:0] a, output logic [7:0] v);
    ppuAddrHi = a[13:10]; #0.5; v = {3'b000, chrBank};
  endtask

  initial begin
    #400000;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8 reset state
    prgAt(16'h8000, v); check("R8 prg", v, 8'h00);
    chrAt(14'h1C00, v); check("R8 chr", v, 8'h00);
    check("R8 ntA10", {7'd0, ntA10}, 8'h00);

    for (int k = 0; k < 10; k++) begin
      cpuWrite(16'h8000, {5'd0, VECS[k].cmd});
      cpuWrite(16'h8001, VECS[k].data);
      if (VECS[k].isPpu) chrAt(VECS[k].addr[13:0], v);
      else               prgAt(VECS[k].addr, v);
      check("R2/R3/R4 table", v, VECS[k].exp);
    end

    // R6 fixed windows
    prgAt(16'hC000, v); check("R6 0xC000", v, 8'hFE);
    prgAt(16'hFFFF, v); check("R6 0xE000", v, 8'hFF);

    // R7/R5: selects are slots 2,3,7 = 1, others 0
    ppuFetch(14'h0000); check("R7 slot0", {7'd0, ntA10}, 8'h00);
    ppuFetch(14'h0800); check("R7 slot2 change", {7'd0, ntA10}, 8'h01);
    ppuFetch(14'h2800); check("R7 nametable fetch ignored", {7'd0, ntA10}, 8'h01);
    ppuFetch(14'h1000); check("R5 slot4", {7'd0, ntA10}, 8'h00);
    ppuFetch(14'h0C00); check("R5 reg1 covers slot3", {7'd0, ntA10}, 8'h01);
    ppuFetch(14'h0400); check("R5 reg0 covers slot1", {7'd0, ntA10}, 8'h00);
    ppuFetch(14'h1C00); check("R7 slot7", {7'd0, ntA10}, 8'h01);

    // R10 live update of the latched slot
    cpuWrite(16'h8000, 8'h05);
    check("R1 command write quiet", {7'd0, ntA10}, 8'h01);
    cpuWrite(16'h8001, 8'h1A);
    check("R10 live select", {7'd0, ntA10}, 8'h00);

    // R9 ignored writes (command still 5)
    cpuWrite(16'h9001, 8'h3F);
    cpuWrite(16'h7001, 8'h3F);
    check("R9 ntA10", {7'd0, ntA10}, 8'h00);
    chrAt(14'h1C00, v); check("R9 chr", v, 8'h1A);

    // R1 mask and upper command bits; R2 persistence
    cpuWrite(16'h8FFE, 8'hF7);
    cpuWrite(16'h8FFF, 8'h5C);
    prgAt(16'hA000, v); check("R1 masked command", v, 8'h5C);
    cpuWrite(16'h8001, 8'h33);
    prgAt(16'hBFFF, v); check("R2 command persists", v, 8'h33);
    prgAt(16'h8000, v); check("R2 other window kept", v, 8'hFF);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule